// File: doc/BRIEF.md
# Scintillator Bar Coincidence Trigger

This block builds a detector trigger from 32 discriminated photosensor hits, two for each of 16 scintillator bars (one at each end). The hits first go through a two-flop synchronizer into the system clock domain. A per-input enable mask then zeroes any disabled channel, and the masked, synchronized channels leave the block as timing outputs. Each surviving end signal is stretched for a programmable number of cycles. A bar counts as hit when the stretched signals of its two ends overlap.

The bars form two groups of eight, one per cable. Each group output is the OR of its bars, and each bar can be enabled on its own by a trigger-mask bit. A control word chooses how the two groups are combined into the global trigger: AND, OR, or disabled. A small state machine (states Off, Armed, Fire, Hold) turns the rising edge of the combined condition into a single-cycle trigger pulse. Transitions: Off→Armed when the mode is valid. Armed→Fire when the condition is true. Fire→Hold while the condition stays true, and Fire→Armed when it drops. Hold→Armed when the condition drops. Any state goes to Off when the mode is invalid. All settings are written through an address/data/write-strobe port.

Top module: `scint_coinc_trigger`

## Requirements
- R1: Each raw input is synchronized by two flops. `tdc_out[i]` equals `hit_in[i]` delayed two clocks and ANDed with input-mask bit i. A masked input never reaches the bar logic.
- R2: Bar n (0..7) of group A is the AND of channels n and n+8. Bar n of group B is the AND of channels 16+n and 24+n. One end alone never produces a bar hit.
- R3: `grp_a` is the registered OR of the group-A bars, where bar n is enabled by trigger-mask bit n.
- R4: `grp_b` is the registered OR of the group-B bars, where bar n is enabled by trigger-mask bit 8+n.
- R5: Control value 0xC0F0 makes the trigger condition `grp_a AND grp_b`. Control value 0xC0FE makes it `grp_a OR grp_b`.
- R6: Any other control value keeps `trig_out` low, while `grp_a` and `grp_b` keep working.
- R7: `trig_out` is a one-cycle pulse on each rising edge of the trigger condition. A held condition gives exactly one pulse.
- R8: A one-cycle end pulse is stretched to L cycles. The two ends of a bar coincide when their synchronized pulses start fewer than L cycles apart. A written L of 0 is treated as 1.
- R9: After reset the input mask, trigger mask and control word are zero and L is 1. All outputs stay low whatever the inputs are.
- R10: Register addresses: 0 is the input mask (32 bits), 1 is the trigger mask (low 16 bits), 2 is the control word (low 16 bits), 3 is L (low 4 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_in | input | 32 | Asynchronous discriminated end hits |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 32 | Register write data |
| tdc_out | output | 32 | Synchronized, masked raw channels |
| grp_a | output | 1 | Group A bar OR |
| grp_b | output | 1 | Group B bar OR |
| trig_out | output | 1 | Global trigger pulse |

## Verification
Every bar is driven with all four end combinations: none, left only, right only, and both. This separates the bar AND from a plain OR and confirms each channel pairing and its group. Single trigger-mask bits are swept with all hits present, to prove that each bit enables exactly one bar in the right group. Single input-mask bits are cleared under a full bar hit, to prove that a disabled channel kills its bar. Group-only patterns under both combine modes and several invalid control words show AND and OR behaving differently and the trigger going quiet. Pulse pairs swept in separation against several stretch lengths locate the edge of the coincidence window.

// File: rtl/scint_trig_pkg.sv
package scint_trig_pkg;
    localparam logic [15:0] CTRL_AND = 16'hC0F0;
    localparam logic [15:0] CTRL_OR  = 16'hC0FE;

    typedef enum logic [1:0] {
        MODE_OFF,
        MODE_AND,
        MODE_OR
    } comb_mode_e;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_ARMED,
        ST_FIRE,
        ST_HOLD
    } trig_state_e;
endpackage

// File: rtl/sct_regs.sv
module sct_regs
    import scint_trig_pkg::*;
#(
    parameter int NIN    = 32,
    parameter int BARS   = 8,
    parameter int LEN_W  = 4,
    parameter int ADDR_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NIN-1:0]      wdata,
    output logic [NIN-1:0]      in_mask,
    output logic [2*BARS-1:0]   trg_mask,
    output comb_mode_e          mode,
    output logic [LEN_W-1:0]    len
);
    logic [15:0] ctrl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_mask  <= '0;
            trg_mask <= '0;
            ctrl_q   <= '0;
            len      <= LEN_W'(1);
        end else if (wr) begin
            case (addr)
                ADDR_W'(0): in_mask  <= wdata;
                ADDR_W'(1): trg_mask <= wdata[2*BARS-1:0];
                ADDR_W'(2): ctrl_q   <= wdata[15:0];
                default:    len      <= (wdata[LEN_W-1:0] == '0) ? LEN_W'(1)
                                                                 : wdata[LEN_W-1:0];
            endcase
        end
    end

    always_comb begin
        if (ctrl_q == CTRL_AND)     mode = MODE_AND;
        else if (ctrl_q == CTRL_OR) mode = MODE_OR;
        else                        mode = MODE_OFF;
    end

    // R8
    len_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len != '0);
endmodule

// File: rtl/sct_front.sv
module sct_front #(
    parameter int NIN   = 32,
    parameter int LEN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NIN-1:0]    hit_in,
    input  logic [NIN-1:0]    in_mask,
    input  logic [LEN_W-1:0]  len,
    output logic [NIN-1:0]    tdc_out,
    output logic [NIN-1:0]    stretched
);
    logic [NIN-1:0] sync1, sync2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= '0;
            sync2 <= '0;
        end else begin
            sync1 <= hit_in;
            sync2 <= sync1;
        end
    end

    assign tdc_out = sync2 & in_mask;

    for (genvar i = 0; i < NIN; i++) begin : g_str
        logic [LEN_W-1:0] cnt;
        always_ff @(posedge clk) begin
            if (!rst_n)           cnt <= '0;
            else if (tdc_out[i])  cnt <= len;
            else if (cnt != '0)   cnt <= cnt - LEN_W'(1);
        end
        assign stretched[i] = (cnt != '0);

        // R8
        stretch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tdc_out[i] |=> (cnt == $past(len)));
        // R1
        masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_mask[i] |-> !tdc_out[i]);
    end
endmodule

// File: rtl/sct_groups.sv
module sct_groups #(
    parameter int BARS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4*BARS-1:0] stretched,
    input  logic [2*BARS-1:0] trg_mask,
    output logic [1:0]        grp
);
    localparam int PER_GRP = 2 * BARS;

    logic [2*BARS-1:0] bars;

    for (genvar g = 0; g < 2; g++) begin : g_grp
        for (genvar n = 0; n < BARS; n++) begin : g_bar
            assign bars[g*BARS + n] = stretched[g*PER_GRP + n]
                                    & stretched[g*PER_GRP + n + BARS];
        end

        logic any_hit;
        assign any_hit = |(bars[g*BARS +: BARS] & trg_mask[g*BARS +: BARS]);

        always_ff @(posedge clk) begin
            if (!rst_n) grp[g] <= 1'b0;
            else        grp[g] <= any_hit;
        end

        // R3 R4
        grp_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grp[g] |-> $past(|(trg_mask[g*BARS +: BARS])));
    end
endmodule

// File: rtl/sct_trig_fsm.sv
module sct_trig_fsm
    import scint_trig_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  comb_mode_e  mode,
    input  logic        grp_a,
    input  logic        grp_b,
    output logic        trig
);
    trig_state_e state, nxt;
    logic cond;

    always_comb begin
        unique case (mode)
            MODE_AND: cond = grp_a & grp_b;
            MODE_OR:  cond = grp_a | grp_b;
            default:  cond = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (mode == MODE_OFF) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:   nxt = ST_ARMED;
                ST_ARMED: nxt = cond ? ST_FIRE : ST_ARMED;
                ST_FIRE:  nxt = cond ? ST_HOLD : ST_ARMED;
                ST_HOLD:  nxt = cond ? ST_HOLD : ST_ARMED;
                default:  nxt = ST_OFF;
            endcase
        end
    end

    always_comb begin
        trig = (state == ST_FIRE);
    end

    // R7
    one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !trig);
    // R5
    trig_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> $past(cond));
    // R6
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF) |=> !trig);
endmodule

// File: rtl/scint_coinc_trigger.sv
module scint_coinc_trigger
    import scint_trig_pkg::*;
#(
    parameter int BARS   = 8,
    parameter int LEN_W  = 4,
    parameter int ADDR_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [4*BARS-1:0]   hit_in,
    input  logic                cfg_wr,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [4*BARS-1:0]   cfg_wdata,
    output logic [4*BARS-1:0]   tdc_out,
    output logic                grp_a,
    output logic                grp_b,
    output logic                trig_out
);
    localparam int NIN = 4 * BARS;

    logic [NIN-1:0]    in_mask;
    logic [2*BARS-1:0] trg_mask;
    comb_mode_e        mode;
    logic [LEN_W-1:0]  len;
    logic [NIN-1:0]    stretched;
    logic [1:0]        grp;

    sct_regs #(.NIN(NIN), .BARS(BARS), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
        .in_mask(in_mask), .trg_mask(trg_mask), .mode(mode), .len(len)
    );

    sct_front #(.NIN(NIN), .LEN_W(LEN_W)) front_i (
        .clk(clk), .rst_n(rst_n), .hit_in(hit_in), .in_mask(in_mask), .len(len),
        .tdc_out(tdc_out), .stretched(stretched)
    );

    sct_groups #(.BARS(BARS)) groups_i (
        .clk(clk), .rst_n(rst_n), .stretched(stretched), .trg_mask(trg_mask),
        .grp(grp)
    );

    assign grp_a = grp[0];
    assign grp_b = grp[1];

    sct_trig_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .grp_a(grp_a), .grp_b(grp_b),
        .trig(trig_out)
    );
endmodule

// File: tb/scint_coinc_trigger_tb_top.sv
module scint_coinc_trigger_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] hit_in = '0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] tdc_out;
    logic        grp_a, grp_b, trig_out;

    int errors = 0;
    int checks = 0;
    int tcount = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    scint_coinc_trigger dut_i (
        .clk(clk), .rst_n(rst_n), .hit_in(hit_in), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .tdc_out(tdc_out),
        .grp_a(grp_a), .grp_b(grp_b), .trig_out(trig_out)
    );

    always @(negedge clk) if (trig_out) tcount++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
        step(1);
        cfg_wr = 1'b0;
        step(1);
    endtask

    function automatic int left_ch(input int bar);
        return (bar < 8) ? bar : 16 + (bar - 8);
    endfunction

    // hold pattern, check groups and tdc, release, check trigger count
    task automatic run(input string req, input logic [31:0] hits, input logic ea,
                       input logic eb, input int et, input logic [31:0] etdc);
        tcount = 0;
        hit_in = hits;
        step(8);
        chk({req, " tdc"}, tdc_out, etdc);
        chk({req, " grp_a"}, {31'd0, grp_a}, {31'd0, ea});
        chk({req, " grp_b"}, {31'd0, grp_b}, {31'd0, eb});
        hit_in = '0;
        step(24);
        chk({req, " trig"}, tcount, et);
    endtask

    task automatic pair(input int len, input int d, input int exp);
        tcount = 0;
        for (int c = 0; c <= d; c++) begin
            hit_in = '0;
            if (c == 0) hit_in[0] = 1'b1;
            if (c == d) hit_in[8] = 1'b1;
            step(1);
        end
        hit_in = '0;
        step(30);
        chk($sformatf("R8 len=%0d d=%0d", len, d), tcount, exp);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R9: everything disabled out of reset
        chk("R9 trig idle", {31'd0, trig_out}, 32'd0);
        run("R9 masked all", 32'hFFFF_FFFF, 1'b0, 1'b0, 0, 32'd0);

        // R10 configure through the register port
        wr(2'd0, 32'hFFFF_FFFF);
        wr(2'd1, 32'h0000_FFFF);
        wr(2'd2, 32'h0000_C0FE);
        wr(2'd3, 32'd2);

        // R1 R2 R3 R4: every bar with every end combination
        for (int b = 0; b < 16; b++) begin
            for (int c = 0; c < 4; c++) begin
                logic [31:0] h;
                logic both;
                h = '0;
                if (c[0]) h[left_ch(b)] = 1'b1;
                if (c[1]) h[left_ch(b) + 8] = 1'b1;
                both = (c == 3);
                run($sformatf("R2 bar%0d c%0d", b, c), h, both && b < 8,
                    both && b >= 8, both ? 1 : 0, h);
            end
        end

        // R3 R4: one trigger-mask bit at a time, all ends hit
        for (int k = 0; k < 16; k++) begin
            wr(2'd1, 32'd1 << k);
            run($sformatf("R3 R4 tmask bit%0d", k), 32'hFFFF_FFFF, k < 8, k >= 8, 1,
                32'hFFFF_FFFF);
        end
        wr(2'd1, 32'h0000_FFFF);

        // R1: clearing one input-mask bit kills its bar
        for (int i = 0; i < 32; i++) begin
            int base;
            logic [31:0] h;
            base = (i < 16) ? 0 : 16;
            h = '0;
            h[base + (i % 8)] = 1'b1;
            h[base + (i % 8) + 8] = 1'b1;
            wr(2'd0, ~(32'd1 << i));
            run($sformatf("R1 inmask%0d", i), h, 1'b0, 1'b0, 0, h & ~(32'd1 << i));
        end
        wr(2'd0, 32'hFFFF_FFFF);

        // R5: AND vs OR
        wr(2'd2, 32'h0000_C0F0);
        run("R5 and A", 32'h0000_0101, 1'b1, 1'b0, 0, 32'h0000_0101);
        run("R5 and B", 32'h0101_0000, 1'b0, 1'b1, 0, 32'h0101_0000);
        run("R5 and AB", 32'h0101_0101, 1'b1, 1'b1, 1, 32'h0101_0101);
        run("R5 and none", 32'h0000_0000, 1'b0, 1'b0, 0, 32'h0);
        wr(2'd2, 32'h0000_C0FE);
        run("R5 or A", 32'h0000_0202, 1'b1, 1'b0, 1, 32'h0000_0202);
        run("R5 or B", 32'h0202_0000, 1'b0, 1'b1, 1, 32'h0202_0000);
        run("R5 or AB", 32'h0202_0202, 1'b1, 1'b1, 1, 32'h0202_0202);

        // R6: undefined control values silence only the trigger
        wr(2'd2, 32'h0000_0000);
        run("R6 ctrl 0000", 32'h0101_0101, 1'b1, 1'b1, 0, 32'h0101_0101);
        wr(2'd2, 32'h0000_C0FF);
        run("R6 ctrl C0FF", 32'h0101_0101, 1'b1, 1'b1, 0, 32'h0101_0101);
        wr(2'd2, 32'h0000_C0F1);
        run("R6 ctrl C0F1", 32'h0101_0101, 1'b1, 1'b1, 0, 32'h0101_0101);
        wr(2'd2, 32'h0000_40F0);
        run("R6 ctrl 40F0", 32'h0101_0101, 1'b1, 1'b1, 0, 32'h0101_0101);
        wr(2'd2, 32'h0000_C0FE);

        // R7: long hold gives one pulse, two separate hits give two
        tcount = 0;
        hit_in = 32'h0000_0101;
        step(60);
        hit_in = '0;
        step(20);
        chk("R7 long hold", tcount, 1);
        tcount = 0;
        hit_in = 32'h0000_0101; step(6); hit_in = '0; step(12);
        hit_in = 32'h0000_0101; step(6); hit_in = '0; step(20);
        chk("R7 two edges", tcount, 2);

        // R8: coincidence window, only bar 0 enabled
        wr(2'd1, 32'h0000_0001);
        for (int l = 1; l <= 4; l++) begin
            wr(2'd3, l);
            for (int d = 0; d <= 5; d++) pair(l, d, (d < l) ? 1 : 0);
        end
        wr(2'd3, 32'd0);
        pair(1, 0, 1);
        pair(1, 1, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule